// File: doc/BRIEF.md
# Masked Bus Breakpoint Comparator

This block watches a snooped bus and raises a break request when a bus cycle fits a programmed pattern. There are four channels. Each channel compares the cycle address with a stored break address, ignoring every bit that is set in its address mask. The two upper channels (2 and 3) can also compare the cycle data with a stored value under their own ignore mask. Each channel qualifies the compare with three 2-bit cycle filters: which master issued the cycle (CPU or DMA), what kind of access it is (instruction fetch or data access), and which way the data moves (read or write).

A qualifying cycle sets a sticky flag for that channel. There is one flag for CPU-issued cycles and one for DMA-issued cycles. The interrupt request output stays high while any flag is set. Channels 2 and 3 also offer a count mode. In this mode the flags are set only on the Nth qualifying cycle, and the count then starts again. Software programs the channels and clears flags through a single-cycle register write port.

Top module: `brk_unit`

## Requirements
- R1: A channel's address compare succeeds when `bus_addr` and the break address are equal on every bit whose address-mask bit is 0. Bits with mask bit 1 are ignored.
- R2: On channels 2 and 3, `bus_data` must also equal the break data on every bit whose data-mask bit is 0, but only when the cycle is a data access (`bus_data_acc`=1). On fetch cycles the data is not compared. Channels 0 and 1 never compare data.
- R3: If any of a channel's three condition fields is 00, that channel never sets a flag, whatever the bus does.
- R4: Each condition field uses this encoding: 01 selects the first option, 10 selects the second, and 11 accepts both. The options are master CPU/DMA (`bus_dma` 0/1), kind fetch/data (`bus_data_acc` 0/1), and direction read/write (`bus_write` 0/1).
- R5: A qualifying cycle (`bus_valid`=1, all compares and filters passing) sets `flag_cpu[ch]` when `bus_dma`=0, or `flag_dma[ch]` when `bus_dma`=1. The flag is visible after the clock edge that samples the cycle.
- R6: Flags are sticky; hardware never clears them. A write to register 6 of a channel replaces the CPU flag with `flag & wdata[0]` and the DMA flag with `flag & wdata[1]`. If a new match arrives in the same cycle, the match wins.
- R7: On channels 2 and 3 with count mode on, an internal counter advances on each qualifying cycle. The flag is set on the cycle where the count reaches the programmed target, and the counter then returns to zero. A target of 0 or 1 fires on every qualifying cycle.
- R8: Writing a channel's count target (register 5) resets its counter to zero.
- R9: `brk_irq` is high exactly while at least one flag is set. It falls only after software has cleared every set flag.
- R10: After reset, all flags and `brk_irq` are 0, all condition fields are 00 (all channels disabled), and all counters are zero.
- R11: On channels 0 and 1 the count-mode bit, and writes to registers 2, 3 and 5, have no effect. These channels flag on every qualifying cycle.
- R12: Write port: `cfg_sel[4:3]` is the channel and `cfg_sel[2:0]` the register. The registers are: 0 break address, 1 address mask, 2 break data, 3 data mask, 4 conditions, 5 count target (low 8 bits), 6 flag clear. Register 7 is unused. The condition word is {count mode [6], direction [5:4], kind [3:2], master [1:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 5 | Channel and register select |
| cfg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | A bus cycle is present |
| bus_addr | input | 32 | Cycle address |
| bus_data | input | 32 | Cycle data |
| bus_dma | input | 1 | 1 = cycle issued by the DMA master |
| bus_data_acc | input | 1 | 1 = data access, 0 = instruction fetch |
| bus_write | input | 1 | 1 = write, 0 = read |
| flag_cpu | output | 4 | Sticky CPU match flags, one per channel |
| flag_dma | output | 4 | Sticky DMA match flags, one per channel |
| brk_irq | output | 1 | Break request |

## Verification
The assertions check the following on every cycle:
- a newly set flag always follows a valid bus cycle from the matching master, and no cycle sets both of a channel's flags;
- a flag or the request falls only right after a register write;
- everything is clear when reset ends.

Only the bench's scenarios can show the functions that depend on programmed values:
- masked address and data compares;
- the condition encodings and disable by 00;
- the Nth-match count and its restart on a target write;
- set-wins-over-clear.

The bench covers these with a reference model, random traffic and directed corner cases.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int REGW = 3;

  localparam logic [REGW-1:0] REG_ADDR  = 3'd0;
  localparam logic [REGW-1:0] REG_AMASK = 3'd1;
  localparam logic [REGW-1:0] REG_DATA  = 3'd2;
  localparam logic [REGW-1:0] REG_DMASK = 3'd3;
  localparam logic [REGW-1:0] REG_COND  = 3'd4;
  localparam logic [REGW-1:0] REG_COUNT = 3'd5;
  localparam logic [REGW-1:0] REG_FLAGS = 3'd6;

  typedef struct packed {
    logic       cnt_mode;
    logic [1:0] dir;
    logic [1:0] kind;
    logic [1:0] master;
  } brk_cond_t;

  localparam int CONDW = $bits(brk_cond_t);

  // 01 = first option only, 10 = second option only, 11 = either
  function automatic logic field_pass(logic [1:0] f, logic second);
    return second ? f[1] : f[0];
  endfunction

  function automatic logic cond_armed(brk_cond_t c);
    return (c.master != 2'b00) && (c.kind != 2'b00) && (c.dir != 2'b00);
  endfunction
endpackage

// File: rtl/brk_masked_cmp.sv
module brk_masked_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] ignore,
  output logic         equal
);
  logic [W-1:0] diff;

  always_comb begin
    diff  = (a ^ b) & ~ignore;
    equal = (diff == '0);
  end
endmodule

// File: rtl/brk_evcount.sv
module brk_evcount #(
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            hit,
  input  logic [CNTW-1:0] target,
  output logic            fire
);
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [CNTW:0]   cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    cnt_d   = cnt_q;
    fire    = 1'b0;
    if (hit) begin
      if (cnt_inc >= {1'b0, target}) begin
        fire  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_inc[CNTW-1:0];
      end
    end
    if (clr) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/brk_channel.sv
module brk_channel
  import brk_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int CNTW     = 8,
  parameter bit HAS_DATA = 1'b0,
  parameter int WW       = (AW > DW) ? AW : DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [REGW-1:0] wr_reg,
  input  logic [WW-1:0]   wr_data,
  input  logic            bus_valid,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_data,
  input  logic            bus_dma,
  input  logic            bus_data_acc,
  input  logic            bus_write,
  output logic            flag_cpu,
  output logic            flag_dma
);
  logic [AW-1:0] addr_q, amask_q;
  brk_cond_t     cond_q;
  logic          addr_we, amask_we, cond_we, flags_wr;
  logic          addr_ok, data_ok, filt_ok, qual_hit;
  logic          use_count, cnt_fire, fire;
  logic          cpu_d, dma_d;

  always_comb begin
    addr_we  = wr_en && (wr_reg == REG_ADDR);
    amask_we = wr_en && (wr_reg == REG_AMASK);
    cond_we  = wr_en && (wr_reg == REG_COND);
    flags_wr = wr_en && (wr_reg == REG_FLAGS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      amask_q <= '0;
      cond_q  <= '0;
    end else begin
      if (addr_we)  addr_q  <= wr_data[AW-1:0];
      if (amask_we) amask_q <= wr_data[AW-1:0];
      if (cond_we)  cond_q  <= brk_cond_t'(wr_data[CONDW-1:0]);
    end
  end

  brk_masked_cmp #(.W(AW)) u_acmp (
    .a      (bus_addr),
    .b      (addr_q),
    .ignore (amask_q),
    .equal  (addr_ok)
  );

  always_comb begin
    filt_ok = cond_armed(cond_q)
           && field_pass(cond_q.master, bus_dma)
           && field_pass(cond_q.kind,   bus_data_acc)
           && field_pass(cond_q.dir,    bus_write);
    qual_hit = bus_valid && filt_ok && addr_ok && data_ok;
  end

  generate
    if (HAS_DATA) begin : g_data
      logic [DW-1:0]   data_q, dmask_q;
      logic [CNTW-1:0] tgt_q;
      logic            data_eq, data_we, dmask_we, tgt_we;

      always_comb begin
        data_we  = wr_en && (wr_reg == REG_DATA);
        dmask_we = wr_en && (wr_reg == REG_DMASK);
        tgt_we   = wr_en && (wr_reg == REG_COUNT);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          data_q  <= '0;
          dmask_q <= '0;
          tgt_q   <= '0;
        end else begin
          if (data_we)  data_q  <= wr_data[DW-1:0];
          if (dmask_we) dmask_q <= wr_data[DW-1:0];
          if (tgt_we)   tgt_q   <= wr_data[CNTW-1:0];
        end
      end

      brk_masked_cmp #(.W(DW)) u_dcmp (
        .a      (bus_data),
        .b      (data_q),
        .ignore (dmask_q),
        .equal  (data_eq)
      );

      assign data_ok   = !bus_data_acc || data_eq;
      assign use_count = cond_q.cnt_mode;

      brk_evcount #(.CNTW(CNTW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tgt_we),
        .hit    (qual_hit && use_count),
        .target (tgt_q),
        .fire   (cnt_fire)
      );
    end else begin : g_nodata
      logic unused_bits;
      assign unused_bits = ^{bus_data, cond_q.cnt_mode};
      assign data_ok     = 1'b1;
      assign use_count   = 1'b0;
      assign cnt_fire    = 1'b0;
    end
  endgenerate

  always_comb begin
    fire  = qual_hit && (use_count ? cnt_fire : 1'b1);
    cpu_d = flags_wr ? (flag_cpu & wr_data[0]) : flag_cpu;
    dma_d = flags_wr ? (flag_dma & wr_data[1]) : flag_dma;
    cpu_d = cpu_d | (fire && !bus_dma);
    dma_d = dma_d | (fire && bus_dma);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_cpu <= 1'b0;
      flag_dma <= 1'b0;
    end else begin
      flag_cpu <= cpu_d;
      flag_dma <= dma_d;
    end
  end
endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int DATA_CH_BASE = 2,
  parameter int AW           = 32,
  parameter int DW           = 32,
  parameter int CNTW         = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [$clog2(NUM_CH)+REGW-1:0]    cfg_sel,
  input  logic [((AW > DW) ? AW : DW)-1:0]  cfg_wdata,
  input  logic                              bus_valid,
  input  logic [AW-1:0]                     bus_addr,
  input  logic [DW-1:0]                     bus_data,
  input  logic                              bus_dma,
  input  logic                              bus_data_acc,
  input  logic                              bus_write,
  output logic [NUM_CH-1:0]                 flag_cpu,
  output logic [NUM_CH-1:0]                 flag_dma,
  output logic                              brk_irq
);
  localparam int CHW = $clog2(NUM_CH);
  localparam int WW  = (AW > DW) ? AW : DW;

  logic [CHW-1:0]  sel_ch;
  logic [REGW-1:0] sel_reg;

  assign sel_ch  = cfg_sel[CHW+REGW-1:REGW];
  assign sel_reg = cfg_sel[REGW-1:0];

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic ch_we;
      assign ch_we = cfg_we && (sel_ch == CHW'(ch));

      brk_channel #(
        .AW       (AW),
        .DW       (DW),
        .CNTW     (CNTW),
        .HAS_DATA (ch >= DATA_CH_BASE),
        .WW       (WW)
      ) u_chan (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (ch_we),
        .wr_reg       (sel_reg),
        .wr_data      (cfg_wdata),
        .bus_valid    (bus_valid),
        .bus_addr     (bus_addr),
        .bus_data     (bus_data),
        .bus_dma      (bus_dma),
        .bus_data_acc (bus_data_acc),
        .bus_write    (bus_write),
        .flag_cpu     (flag_cpu[ch]),
        .flag_dma     (flag_dma[ch])
      );
    end
  endgenerate

  assign brk_irq = |{flag_cpu, flag_dma};
endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              bus_valid,
  input logic              bus_dma,
  input logic [NUM_CH-1:0] flag_cpu,
  input logic [NUM_CH-1:0] flag_dma,
  input logic              brk_irq
);
  p_cpu_flag_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_cpu & ~$past(flag_cpu)) != '0) |-> ($past(bus_valid) && !$past(bus_dma)));

  p_dma_flag_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_dma & ~$past(flag_dma)) != '0) |-> ($past(bus_valid) && $past(bus_dma)));

  p_one_master_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (((flag_cpu & ~$past(flag_cpu)) & (flag_dma & ~$past(flag_dma))) == '0));

  p_cpu_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((~flag_cpu & $past(flag_cpu)) != '0) |-> $past(cfg_we));

  p_dma_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((~flag_dma & $past(flag_dma)) != '0) |-> $past(cfg_we));

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_irq) |-> $past(cfg_we));

  p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (flag_cpu == '0 && flag_dma == '0 && !brk_irq));
endmodule

bind brk_unit brk_unit_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .bus_valid (bus_valid),
  .bus_dma   (bus_dma),
  .flag_cpu  (flag_cpu),
  .flag_dma  (flag_dma),
  .brk_irq   (brk_irq)
);

// File: tb/brk_unit_tb.sv
`timescale 1ns/1ps
module brk_unit_tb;
  logic        clk, rst_n, cfg_we;
  logic [4:0]  cfg_sel;
  logic [31:0] cfg_wdata, bus_addr, bus_data;
  logic        bus_valid, bus_dma, bus_data_acc, bus_write;
  logic [3:0]  flag_cpu, flag_dma;
  logic        brk_irq;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [31:0] m_addr [4], m_amask [4], m_data [4], m_dmask [4];
  logic [6:0]  m_cond [4];
  logic [7:0]  m_tgt [4];
  int          m_cnt [4];
  logic [3:0]  m_fc, m_fd;

  brk_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data), .bus_dma(bus_dma),
    .bus_data_acc(bus_data_acc), .bus_write(bus_write),
    .flag_cpu(flag_cpu), .flag_dma(flag_dma), .brk_irq(brk_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [6:0] cond(bit cm, logic [1:0] dir, logic [1:0] kind, logic [1:0] mst);
    return {cm, dir, kind, mst};
  endfunction

  function automatic bit fsel(logic [1:0] f, bit second);
    return second ? f[1] : f[0];
  endfunction

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: {dma,cpu,irq} got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic model_update();
    int ch_w;
    int rg;
    ch_w = int'(cfg_sel[4:3]);
    rg   = int'(cfg_sel[2:0]);
    for (int ch = 0; ch < 4; ch++) begin
      bit hit, ev, kc, kd, cm;
      int ncnt;
      ev   = 0;
      ncnt = m_cnt[ch];
      hit  = bus_valid && (m_cond[ch][1:0] != 0) && (m_cond[ch][3:2] != 0) && (m_cond[ch][5:4] != 0)
          && fsel(m_cond[ch][1:0], bus_dma) && fsel(m_cond[ch][3:2], bus_data_acc)
          && fsel(m_cond[ch][5:4], bus_write)
          && (((bus_addr ^ m_addr[ch]) & ~m_amask[ch]) == 0)
          && (ch < 2 || !bus_data_acc || (((bus_data ^ m_data[ch]) & ~m_dmask[ch]) == 0));
      cm = (ch >= 2) && m_cond[ch][6];
      if (hit) begin
        if (cm) begin
          if (m_cnt[ch] + 1 >= int'(m_tgt[ch])) begin ev = 1; ncnt = 0; end
          else ncnt = m_cnt[ch] + 1;
        end else ev = 1;
      end
      kc = 1; kd = 1;
      if (cfg_we && ch_w == ch && rg == 6) begin kc = cfg_wdata[0]; kd = cfg_wdata[1]; end
      m_fc[ch] = (m_fc[ch] & kc) | (ev & !bus_dma);
      m_fd[ch] = (m_fd[ch] & kd) | (ev & bus_dma);
      if (cfg_we && ch_w == ch) begin
        case (rg)
          0: m_addr[ch]  = cfg_wdata;
          1: m_amask[ch] = cfg_wdata;
          2: m_data[ch]  = cfg_wdata;
          3: m_dmask[ch] = cfg_wdata;
          4: m_cond[ch]  = cfg_wdata[6:0];
          5: begin m_tgt[ch] = cfg_wdata[7:0]; ncnt = 0; end
          default: ;
        endcase
      end
      m_cnt[ch] = ncnt;
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    check(tag, {flag_dma, flag_cpu, brk_irq}, {m_fd, m_fc, |{m_fd, m_fc}});
    cfg_we = 0; bus_valid = 0;
  endtask

  task automatic wr(int ch, int rg, logic [31:0] d, string tag);
    cfg_we = 1; cfg_sel = {ch[1:0], rg[2:0]}; cfg_wdata = d;
    step(tag);
  endtask

  task automatic bus(logic [31:0] a, logic [31:0] d, bit dma, bit dacc, bit w, string tag);
    bus_valid = 1; bus_addr = a; bus_data = d; bus_dma = dma; bus_data_acc = dacc; bus_write = w;
    step(tag);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got hung expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; bus_valid = 0;
    bus_addr = 0; bus_data = 0; bus_dma = 0; bus_data_acc = 0; bus_write = 0;
    for (int i = 0; i < 4; i++) begin
      m_addr[i] = 0; m_amask[i] = 0; m_data[i] = 0; m_dmask[i] = 0;
      m_cond[i] = 0; m_tgt[i] = 0; m_cnt[i] = 0;
    end
    m_fc = 0; m_fd = 0;
    repeat (3) @(negedge clk);
    check("R10 reset", {flag_dma, flag_cpu, brk_irq}, 9'b0);
    rst_n = 1;
    @(negedge clk);
    bus(32'h0, 32'h0, 0, 0, 0, "R10 disabled after reset");

    // R1 masked address on channel 0, CPU only
    wr(0, 0, 32'h1000, "R12 addr");
    wr(0, 1, 32'h0000_000F, "R12 amask");
    wr(0, 4, cond(0, 2'b11, 2'b11, 2'b01), "R12 cond");
    bus(32'h100A, 0, 0, 0, 0, "R1 masked bits ignored");
    wr(0, 6, 0, "R6 clear");
    bus(32'h1010, 0, 0, 0, 0, "R1 unmasked bit differs");
    bus(32'h1003, 0, 1, 0, 0, "R4 master filter rejects DMA");
    // R3 disabled by 00 field
    wr(1, 0, 32'h2000, "R12 addr ch1");
    wr(1, 4, cond(0, 2'b11, 2'b00, 2'b11), "R12 cond ch1");
    bus(32'h2000, 0, 0, 0, 0, "R3 kind field 00");
    bus(32'h2000, 0, 1, 1, 1, "R3 kind field 00 dma");
    // R5 separate master flags
    wr(1, 4, cond(0, 2'b11, 2'b11, 2'b11), "R12 cond ch1 any");
    bus(32'h2000, 0, 1, 1, 0, "R5 dma flag");
    bus(32'h2000, 0, 0, 0, 1, "R5 cpu flag");
    wr(1, 6, 32'h2, "R6 keep dma clear cpu");
    cfg_we = 1; cfg_sel = {2'd1, 3'd6}; cfg_wdata = 0;
    bus_valid = 1; bus_addr = 32'h2000; bus_dma = 1; bus_data_acc = 0; bus_write = 0;
    step("R6 set wins over clear");
    bus(32'h2000, 0, 0, 0, 0, "R6 sticky");
    wr(0, 6, 0, "R9 clear ch0");
    wr(1, 6, 32'h1, "R9 partial clear keeps irq");
    wr(1, 6, 0, "R9 irq falls after last clear");
    // R2 data compare on channel 2
    wr(2, 0, 32'h3000, "R12 addr ch2");
    wr(2, 2, 32'h0000_00AB, "R12 data ch2");
    wr(2, 3, 32'hFFFF_FF00, "R12 dmask ch2");
    wr(2, 4, cond(0, 2'b11, 2'b11, 2'b11), "R12 cond ch2");
    bus(32'h3000, 32'h555, 0, 0, 0, "R2 fetch ignores data");
    wr(2, 6, 0, "R6 clear ch2");
    bus(32'h3000, 32'h1234_56AC, 0, 1, 0, "R2 data miss");
    bus(32'h3000, 32'h7777_77AB, 0, 1, 0, "R2 data hit");
    wr(2, 6, 0, "R6 clear ch2");
    wr(2, 4, cond(0, 2'b10, 2'b10, 2'b11), "R12 write-only data");
    bus(32'h3000, 32'hAB, 1, 1, 0, "R4 direction read rejected");
    bus(32'h3000, 32'hAB, 1, 0, 1, "R4 kind fetch rejected");
    bus(32'h3000, 32'hAB, 1, 1, 1, "R4 write data accepted");
    wr(2, 6, 0, "R6 clear ch2");
    // R7 count mode on channel 3
    wr(3, 0, 32'h4000, "R12 addr ch3");
    wr(3, 3, 32'hFFFF_FFFF, "R12 dmask ch3");
    wr(3, 5, 3, "R12 target ch3");
    wr(3, 4, cond(1, 2'b11, 2'b11, 2'b11), "R12 cond ch3 count");
    for (int i = 0; i < 3; i++) bus(32'h4000, 0, 0, 1, 0, "R7 count to three");
    wr(3, 6, 0, "R6 clear ch3");
    for (int i = 0; i < 3; i++) bus(32'h4000, 0, 1, 1, 1, "R7 restart after fire");
    wr(3, 6, 0, "R6 clear ch3");
    // R8 target rewrite restarts count
    bus(32'h4000, 0, 0, 1, 0, "R8 first");
    bus(32'h4000, 0, 0, 1, 0, "R8 second");
    wr(3, 5, 3, "R8 rewrite target");
    for (int i = 0; i < 3; i++) bus(32'h4000, 0, 0, 1, 0, "R8 full count needed");
    wr(3, 6, 0, "R6 clear ch3");
    wr(3, 5, 0, "R7 target zero");
    bus(32'h4000, 0, 0, 1, 0, "R7 target zero fires");
    // R11 count bit ignored on channel 0
    wr(0, 5, 9, "R11 count write ignored");
    wr(0, 2, 32'hDEAD, "R11 data write ignored");
    wr(0, 4, cond(1, 2'b11, 2'b11, 2'b11), "R11 cond with count bit");
    bus(32'h1005, 32'h0, 0, 1, 0, "R11 fires on first match");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 25) begin
        int ch, rg;
        ch = int'($urandom % 4);
        rg = int'($urandom % 8);
        cfg_we = 1; cfg_sel = {ch[1:0], rg[2:0]};
        cfg_wdata = (rg == 5) ? ($urandom % 6) : (rg == 6) ? ($urandom % 4) : $urandom;
      end
      if (r >= 15) begin
        int k;
        k = int'($urandom % 4);
        bus_valid = 1;
        bus_addr = m_addr[k] ^ ($urandom & m_amask[k]);
        bus_data = m_data[k] ^ ($urandom & m_dmask[k]);
        if ($urandom % 8 == 0) bus_addr = bus_addr ^ (32'h1 << ($urandom % 32));
        if ($urandom % 8 == 0) bus_data = bus_data ^ (32'h1 << ($urandom % 32));
        bus_dma = $urandom % 2; bus_data_acc = $urandom % 2; bus_write = $urandom % 2;
      end
      step("R1 R2 R4 R5 R6 R7 random");
    end
    done = 1;
    finish_run();
  end
endmodule